// File: doc/BRIEF.md
# Transmit Flow-Control Credit Gate

This block sits in the transmit path of a PCI Express transaction layer and decides, cycle by cycle, whether the transaction packet at the head of the queue may go out. It keeps separate credit state for three traffic classes: posted, non-posted and completion. Each class has a header pool and a data pool, and each pool holds an advertised limit and a locally consumed count. A packet is granted only when both pools of its class can cover it. A header costs one credit. Data costs one credit per 16 bytes of payload, which is four dwords, rounded up.

The packet source presents a descriptor with valid/ready handshaking. The descriptor gives the class and the payload length in dwords. The grant is the ready signal. It is computed in the same cycle from the registered credit state, and the consumed counters advance on the clock edge where valid and ready are both high. A per-class update strobe loads new limits from the link partner's advertisements.

Credit room is computed with modular arithmetic, so the counters may wrap freely. A pool whose first advertised limit is zero is unlimited. Completion credit is never allowed to block.

Top module: `fc_credit_gate`

## Requirements
- R1: The class code on `tlpKind` is 0 for posted, 1 for non-posted, 2 for completion and 3 for reserved. `tlpReady` is high only while `tlpValid` is high and the code is 0, 1 or 2. Code 3 is never granted.
- R2: After reset, and before the first limit update of a class, both pools of that class are unlimited, so a packet of that class is granted.
- R3: A limited header pool allows a packet only if (limit − (consumed + 1)) mod 256 is below 128.
- R4: A packet needs ceil(length/4) data credits. A limited data pool allows it only if (limit − (consumed + need)) mod 4096 is below 2048. A length of 0 needs no data credit.
- R5: The consumed counters of a class change only on a completed handshake of that class. The header counter grows by one and the data counter by the need, both wrapping modulo their width.
- R6: The first limit update of a class after reset marks each of its pools unlimited if the loaded value is zero. That marking persists until reset. A later update with a zero value is an ordinary limit.
- R7: A limit loaded by an update strobe takes effect in the cycle after the strobe. A packet presented in the same cycle as the strobe is judged against the old limit.
- R8: With the default parameter setting, a valid completion is always granted, whatever its completion limits are.
- R9: A packet that is refused stays refused while its descriptor is unchanged and no limit update occurs.
- R10: The grant is combinational. When the credits allow it, a packet is granted in the same cycle it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tlpValid | input | 1 | Descriptor valid |
| tlpKind | input | 2 | Class code: 0 posted, 1 non-posted, 2 completion, 3 reserved |
| tlpLenDw | input | LEN_W (11) | Payload length in dwords |
| tlpReady | output | 1 | Grant; the handshake completes when valid and ready are both high |
| limitUpd | input | 3 | Per-class limit load strobe; bit n is class code n |
| postHdrLimit | input | HDR_W (8) | Posted header limit |
| postDatLimit | input | DAT_W (12) | Posted data limit |
| npHdrLimit | input | HDR_W (8) | Non-posted header limit |
| npDatLimit | input | DAT_W (12) | Non-posted data limit |
| cplHdrLimit | input | HDR_W (8) | Completion header limit |
| cplDatLimit | input | DAT_W (12) | Completion data limit |

## Verification
The grant answers a descriptor in the same cycle. An update strobe or a completed handshake changes later grants from the following cycle. The bench drives each descriptor just after a falling edge and queues the grant expected from hand-worked credit arithmetic. A monitor samples `tlpReady` two nanoseconds later, before the next rising edge. Limit loads and consumption are observed in the cycle after the edge that registers them. That includes a case where a strobe and a descriptor share a cycle and the descriptor is judged against the old limit.

// File: rtl/fc_gate_pkg.sv
package fc_gate_pkg;
  localparam int NUM_KINDS = 3;

  typedef enum logic [1:0] {
    KIND_POSTED     = 2'd0,
    KIND_NONPOSTED  = 2'd1,
    KIND_COMPLETION = 2'd2,
    KIND_RESERVED   = 2'd3
  } tlpKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic [NUM_KINDS-1:0] consume;  // one-hot: class that completed a handshake
  } ctrlStrobe_t;
endpackage

// File: rtl/fc_gate_dpath.sv
module fc_gate_dpath
  import fc_gate_pkg::*;
#(
  parameter int HDR_W = 8,
  parameter int DAT_W = 12
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_KINDS-1:0] limitUpd,
  input  logic [HDR_W-1:0]     hdrLimitIn [NUM_KINDS],
  input  logic [DAT_W-1:0]     datLimitIn [NUM_KINDS],
  input  ctrlStrobe_t          strobe,
  input  logic [DAT_W-1:0]     datNeed,
  output logic [HDR_W-1:0]     hdrLimit [NUM_KINDS],
  output logic [DAT_W-1:0]     datLimit [NUM_KINDS],
  output logic [HDR_W-1:0]     hdrCons  [NUM_KINDS],
  output logic [DAT_W-1:0]     datCons  [NUM_KINDS],
  output logic [NUM_KINDS-1:0] hdrInf,
  output logic [NUM_KINDS-1:0] datInf
);
  logic [NUM_KINDS-1:0] seenUpd;

  for (genvar t = 0; t < NUM_KINDS; t++) begin : g_pool
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        hdrLimit[t] <= '0;
        datLimit[t] <= '0;
        hdrCons[t]  <= '0;
        datCons[t]  <= '0;
        hdrInf[t]   <= 1'b1;
        datInf[t]   <= 1'b1;
        seenUpd[t]  <= 1'b0;
      end else begin
        if (limitUpd[t]) begin
          hdrLimit[t] <= hdrLimitIn[t];
          datLimit[t] <= datLimitIn[t];
          if (!seenUpd[t]) begin
            hdrInf[t]  <= (hdrLimitIn[t] == '0);
            datInf[t]  <= (datLimitIn[t] == '0);
            seenUpd[t] <= 1'b1;
          end
        end
        if (strobe.consume[t]) begin
          hdrCons[t] <= hdrCons[t] + 1'b1;
          datCons[t] <= datCons[t] + datNeed;
        end
      end
    end

    // R5: header count steps by one per handshake, else holds
    a_r5_hdr_step: assert property (@(posedge clk) disable iff (!rstN)
      $past(strobe.consume[t]) |-> hdrCons[t] == HDR_W'($past(hdrCons[t]) + 1'b1));
    a_r5_hdr_hold: assert property (@(posedge clk) disable iff (!rstN)
      !$past(strobe.consume[t]) |-> $stable(hdrCons[t]));
    // R5: data count steps by the need computed in control
    a_r5_dat_step: assert property (@(posedge clk) disable iff (!rstN)
      $past(strobe.consume[t]) |-> datCons[t] == DAT_W'($past(datCons[t]) + $past(datNeed)));
    // R6: unlimited marking is fixed once the first update has been seen
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rstN)
      $past(seenUpd[t]) |-> ($stable(hdrInf[t]) && $stable(datInf[t])));
  end

  a_r5_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe.consume));
endmodule

// File: rtl/fc_gate_ctrl.sv
module fc_gate_ctrl
  import fc_gate_pkg::*;
#(
  parameter int HDR_W         = 8,
  parameter int DAT_W         = 12,
  parameter int LEN_W         = 11,
  parameter bit CPL_UNLIMITED = 1'b1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tlpValid,
  input  logic [1:0]           tlpKind,
  input  logic [LEN_W-1:0]     tlpLenDw,
  input  logic [HDR_W-1:0]     hdrLimit [NUM_KINDS],
  input  logic [DAT_W-1:0]     datLimit [NUM_KINDS],
  input  logic [HDR_W-1:0]     hdrCons  [NUM_KINDS],
  input  logic [DAT_W-1:0]     datCons  [NUM_KINDS],
  input  logic [NUM_KINDS-1:0] hdrInf,
  input  logic [NUM_KINDS-1:0] datInf,
  output logic                 tlpReady,
  output ctrlStrobe_t          strobe,
  output logic [DAT_W-1:0]     datNeed
);
  localparam int LENP_W = LEN_W + 1;

  logic [LENP_W-1:0]    lenPlus;
  logic [NUM_KINDS-1:0] poolOk;

  // round the dword count up to 4-dword credit units
  assign lenPlus = {1'b0, tlpLenDw} + LENP_W'(3);
  assign datNeed = DAT_W'(lenPlus[LENP_W-1:2]);

  for (genvar t = 0; t < NUM_KINDS; t++) begin : g_check
    if (CPL_UNLIMITED && t == int'(KIND_COMPLETION)) begin : g_free
      assign poolOk[t] = 1'b1;
    end else begin : g_mod
      logic [HDR_W-1:0] hdrRoom;
      logic [DAT_W-1:0] datRoom;
      assign hdrRoom   = hdrLimit[t] - hdrCons[t] - HDR_W'(1);
      assign datRoom   = datLimit[t] - datCons[t] - datNeed;
      assign poolOk[t] = (hdrInf[t] | ~hdrRoom[HDR_W-1]) &
                         (datInf[t] | ~datRoom[DAT_W-1]);
    end
  end

  always_comb begin
    tlpReady       = 1'b0;
    strobe.consume = '0;
    if (tlpValid && tlpKind != KIND_RESERVED) begin
      tlpReady = poolOk[tlpKind];
      strobe.consume[tlpKind] = poolOk[tlpKind];
    end
  end

  // R1: reserved class code is never granted
  a_r1_reserved: assert property (@(posedge clk) disable iff (!rstN)
    (tlpKind == KIND_RESERVED) |-> !tlpReady);
  // R1: no grant without valid
  a_r1_novalid: assert property (@(posedge clk) disable iff (!rstN)
    !tlpValid |-> !tlpReady);

  if (CPL_UNLIMITED) begin : g_cpl_chk
    // R8: completions never wait for credit
    a_r8_cpl_free: assert property (@(posedge clk) disable iff (!rstN)
      (tlpValid && tlpKind == KIND_COMPLETION) |-> tlpReady);
  end
endmodule

// File: rtl/fc_credit_gate.sv
module fc_credit_gate
  import fc_gate_pkg::*;
#(
  parameter int HDR_W         = 8,
  parameter int DAT_W         = 12,
  parameter int LEN_W         = 11,
  parameter bit CPL_UNLIMITED = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tlpValid,
  input  logic [1:0]       tlpKind,
  input  logic [LEN_W-1:0] tlpLenDw,
  output logic             tlpReady,
  input  logic [2:0]       limitUpd,
  input  logic [HDR_W-1:0] postHdrLimit,
  input  logic [DAT_W-1:0] postDatLimit,
  input  logic [HDR_W-1:0] npHdrLimit,
  input  logic [DAT_W-1:0] npDatLimit,
  input  logic [HDR_W-1:0] cplHdrLimit,
  input  logic [DAT_W-1:0] cplDatLimit
);
  logic [HDR_W-1:0]     hdrLimitIn [NUM_KINDS];
  logic [DAT_W-1:0]     datLimitIn [NUM_KINDS];
  logic [HDR_W-1:0]     hdrLimit   [NUM_KINDS];
  logic [DAT_W-1:0]     datLimit   [NUM_KINDS];
  logic [HDR_W-1:0]     hdrCons    [NUM_KINDS];
  logic [DAT_W-1:0]     datCons    [NUM_KINDS];
  logic [NUM_KINDS-1:0] hdrInf;
  logic [NUM_KINDS-1:0] datInf;
  ctrlStrobe_t          strobe;
  logic [DAT_W-1:0]     datNeed;

  assign hdrLimitIn[0] = postHdrLimit;
  assign hdrLimitIn[1] = npHdrLimit;
  assign hdrLimitIn[2] = cplHdrLimit;
  assign datLimitIn[0] = postDatLimit;
  assign datLimitIn[1] = npDatLimit;
  assign datLimitIn[2] = cplDatLimit;

  fc_gate_ctrl #(
    .HDR_W(HDR_W), .DAT_W(DAT_W), .LEN_W(LEN_W), .CPL_UNLIMITED(CPL_UNLIMITED)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .tlpValid(tlpValid), .tlpKind(tlpKind), .tlpLenDw(tlpLenDw),
    .hdrLimit(hdrLimit), .datLimit(datLimit),
    .hdrCons(hdrCons), .datCons(datCons),
    .hdrInf(hdrInf), .datInf(datInf),
    .tlpReady(tlpReady), .strobe(strobe), .datNeed(datNeed)
  );

  fc_gate_dpath #(
    .HDR_W(HDR_W), .DAT_W(DAT_W)
  ) u_dpath (
    .clk(clk), .rstN(rstN),
    .limitUpd(limitUpd),
    .hdrLimitIn(hdrLimitIn), .datLimitIn(datLimitIn),
    .strobe(strobe), .datNeed(datNeed),
    .hdrLimit(hdrLimit), .datLimit(datLimit),
    .hdrCons(hdrCons), .datCons(datCons),
    .hdrInf(hdrInf), .datInf(datInf)
  );

  // R9: a refused packet stays refused while nothing relevant changes
  a_r9_stall_holds: assert property (@(posedge clk) disable iff (!rstN)
    ($past(tlpValid && !tlpReady && limitUpd == '0) && tlpValid &&
     $stable(tlpKind) && $stable(tlpLenDw)) |-> !tlpReady);
endmodule

// File: tb/tb_fc_credit_gate.sv
`timescale 1ns/1ps
module tb_fc_credit_gate;
  localparam int HDR_W = 8;
  localparam int DAT_W = 12;
  localparam int LEN_W = 11;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             tlpValid = 1'b0;
  logic [1:0]       tlpKind = 2'd0;
  logic [LEN_W-1:0] tlpLenDw = '0;
  logic             tlpReady;
  logic [2:0]       limitUpd = 3'b000;
  logic [HDR_W-1:0] postHdrLimit = '0, npHdrLimit = '0, cplHdrLimit = '0;
  logic [DAT_W-1:0] postDatLimit = '0, npDatLimit = '0, cplDatLimit = '0;

  int checks = 0;
  int fails  = 0;
  bit expQ[$];
  string tagQ[$];
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fc_credit_gate dut (
    .clk(clk), .rstN(rstN),
    .tlpValid(tlpValid), .tlpKind(tlpKind), .tlpLenDw(tlpLenDw),
    .tlpReady(tlpReady), .limitUpd(limitUpd),
    .postHdrLimit(postHdrLimit), .postDatLimit(postDatLimit),
    .npHdrLimit(npHdrLimit), .npDatLimit(npDatLimit),
    .cplHdrLimit(cplHdrLimit), .cplDatLimit(cplDatLimit)
  );

  // monitor: compare the grant against the queued expectation
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (expQ.size() > 0) begin
        bit e;
        string g;
        e = expQ.pop_front();
        g = tagQ.pop_front();
        checks++;
        if (tlpReady !== e) begin
          fails++;
          $display("FAIL %s: tlpReady=%b expected=%b at %0t", g, tlpReady, e, $time);
        end
      end
    end
  end

  task automatic sendTlp(input logic [1:0] k, input int len, input bit e, input string g);
    @(negedge clk);
    limitUpd = 3'b000;
    tlpValid = 1'b1;
    tlpKind  = k;
    tlpLenDw = LEN_W'(len);
    expQ.push_back(e);
    tagQ.push_back(g);
  endtask

  task automatic idleCheck(input string g);
    @(negedge clk);
    tlpValid = 1'b0;
    limitUpd = 3'b000;
    expQ.push_back(1'b0);
    tagQ.push_back(g);
  endtask

  task automatic setLimits(input int k, input int h, input int d);
    case (k)
      0: begin postHdrLimit = HDR_W'(h); postDatLimit = DAT_W'(d); end
      1: begin npHdrLimit = HDR_W'(h); npDatLimit = DAT_W'(d); end
      default: begin cplHdrLimit = HDR_W'(h); cplDatLimit = DAT_W'(d); end
    endcase
  endtask

  task automatic loadLimits(input int k, input int h, input int d);
    @(negedge clk);
    tlpValid = 1'b0;
    setLimits(k, h, d);
    limitUpd = 3'(1 << k);
    @(negedge clk);
    limitUpd = 3'b000;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    idleCheck("R1 reset/no valid");
    // R2: before any update, pools unlimited. posted cons -> h1 d1
    sendTlp(2'd0, 4, 1'b1, "R2 unlimited before update");
    sendTlp(2'd3, 4, 1'b0, "R1 reserved code");
    loadLimits(0, 3, 4);
    loadLimits(1, 1, 0);
    loadLimits(2, 1, 1);
    // R4/R10: 8 dwords need 2 data credits: 4-(1+2)=1 ok -> h2 d3
    sendTlp(2'd0, 8, 1'b1, "R4 data fits");
    // R4: 4-(3+2) negative -> refused; R9 stays refused
    sendTlp(2'd0, 8, 1'b0, "R4 data short");
    sendTlp(2'd0, 8, 1'b0, "R9 stall holds");
    loadLimits(0, 3, 5);
    sendTlp(2'd0, 8, 1'b1, "R4 exact fit after update"); // -> h3 d5
    // R3: header 3-(3+1) negative
    sendTlp(2'd0, 0, 1'b0, "R3 header short");
    loadLimits(0, 4, 5);
    sendTlp(2'd0, 0, 1'b1, "R4 zero length needs no data"); // -> h4 d5
    // R6: np data limit zero on first update is unlimited; hdr limit 1
    sendTlp(2'd1, 1, 1'b1, "R6 np zero data limit unlimited"); // np h1
    sendTlp(2'd1, 0, 1'b0, "R3 np header short");
    sendTlp(2'd1, 1024, 1'b0, "R3 np header short long");
    loadLimits(1, 2, 5);
    sendTlp(2'd1, 1024, 1'b1, "R6 unlimited sticky after update");
    // R8: completion limits tiny but never block
    sendTlp(2'd2, 64, 1'b1, "R8 cpl free 1");
    sendTlp(2'd2, 64, 1'b1, "R8 cpl free 2");
    sendTlp(2'd2, 64, 1'b1, "R8 cpl free 3");
    // R6: later zero update is a real limit: 0-(4+1) negative
    loadLimits(0, 0, 5);
    sendTlp(2'd0, 0, 1'b0, "R6 later zero is a limit");
    // R7: strobe and descriptor in the same cycle: old limit applies
    @(negedge clk);
    setLimits(0, 10, 20);
    limitUpd = 3'b001;
    tlpValid = 1'b1; tlpKind = 2'd0; tlpLenDw = '0;
    expQ.push_back(1'b0); tagQ.push_back("R7 same-cycle update uses old limit");
    sendTlp(2'd0, 0, 1'b1, "R7 new limit next cycle"); // -> h5 d5
    idleCheck("R5 no valid no grant");
    // R5: wrap the header counter through modular arithmetic
    for (int i = 0; i < 3; i++) begin
      loadLimits(0, (5 + 100 * (i + 1)) % 256, 5 + 100 * (i + 1));
      for (int j = 0; j < 100; j++) sendTlp(2'd0, 4, 1'b1, "R5 counted grant");
      sendTlp(2'd0, 4, 1'b0, "R5 exhausted after wrap");
    end
    idleCheck("R1 idle at end");
    @(negedge clk);
    tlpValid = 1'b0;
    wait (expQ.size() == 0);
    @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule